// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block sits between instruction decode and the load/store datapath. For each request it either returns an operand value directly or forms an effective memory address, using one of several addressing modes. It can also produce an updated base-register value to write back. The modes are immediate, register, base plus displacement (PC-relative when the program counter is chosen as base), base plus index, scaled index, post-increment, post-decrement, pre-update, and a two-access memory-indirect form.

A request is a one-cycle `start` pulse with the mode code and its source values. Single-step modes return their result one cycle later. The memory-indirect mode reads a pointer through a synchronous read port of one-cycle latency, then returns that pointer as the final address. While that sequence runs, `busy` is high and new requests are ignored. All address arithmetic is 32-bit and wraps around without any trap.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, `done`, `operand_valid`, `addr_valid`, `wb_en`, `illegal`, `mem_req` and `busy` are all low.
- R2: Mode 0 returns `imm` as `operand`. Mode 1 returns `base_val` as `operand`. In both modes `operand_valid` is high, and `addr_valid`, `wb_en` and `mem_req` stay low.
- R3: Mode 2 gives `addr` = base + `disp`, where base is `pc` when `base_is_pc` is 1 and `base_val` otherwise. A zero `disp` gives register-indirect addressing.
- R4: Mode 3 gives `addr` = `base_val` + `index_val`. Mode 4 gives `addr` = `base_val` + (`index_val` << `scale_sel`), so the scale is 1, 2, 4 or 8.
- R5: Mode 5 gives `addr` = `base_val` and `wb_value` = `base_val` + `step`. Mode 6 gives `addr` = `base_val` and `wb_value` = `base_val` − `step`. In both modes `wb_en` is high.
- R6: Mode 7 sets both `addr` and `wb_value` to `base_val` + `disp`, with `wb_en` high.
- R7: For modes 0 to 7 and for illegal codes, `done` and the results appear in the cycle after the cycle in which `start` is sampled.
- R8: Mode 8 drives `mem_req` high with `mem_addr` = `base_val` in the cycle after start. `mem_rdata` is taken in the cycle after that. In the third cycle after start, `done` and `addr_valid` are high and `addr` equals that word.
- R9: `busy` is high in both memory-indirect wait cycles. A `start` seen while `busy` is high is ignored and produces no result.
- R10: Mode codes 9 to 15 raise `illegal` together with `done`. In that case `addr_valid`, `operand_valid` and `wb_en` stay low.
- R11: All address and write-back sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| mode | input | 4 | Addressing mode code |
| base_is_pc | input | 1 | Use `pc` as the base in mode 2 |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| disp | input | 32 | Sign-extended displacement |
| imm | input | 32 | Immediate constant |
| pc | input | 32 | Program counter |
| scale_sel | input | 2 | Index shift amount, 0 to 3 |
| step | input | 3 | Access size in bytes for post-increment and post-decrement |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_req` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| busy | output | 1 | Memory-indirect sequence in progress |
| done | output | 1 | Result pulse |
| illegal | output | 1 | Undefined mode flag |
| operand_valid | output | 1 | `operand` carries a value |
| operand | output | 32 | Immediate or register operand |
| addr_valid | output | 1 | `addr` carries an effective address |
| addr | output | 32 | Effective address |
| wb_en | output | 1 | Base write-back request |
| wb_value | output | 32 | Updated base value |

## Verification
Every mode is driven with distinct base, index, displacement and immediate values. A result taken from the wrong source or the wrong adder therefore gives a different number. Scaled index is run with all four shift amounts on the same operands, which separates each scale. Both the plain and PC base are used with one displacement to expose a wrong base selection. Wrapping sums at the top and bottom of the address space check the modulo behaviour. The indirect mode uses a memory whose data differs from its address, so the bench can tell the pointer word apart from the base. A start issued mid-sequence must leave no trace.

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   mode,
  input  logic         base_is_pc,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] index_val,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] pc,
  input  logic [1:0]   scale_sel,
  input  logic [2:0]   step,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  output logic         busy,
  output logic         done,
  output logic         illegal,
  output logic         operand_valid,
  output logic [W-1:0] operand,
  output logic         addr_valid,
  output logic [W-1:0] addr,
  output logic         wb_en,
  output logic [W-1:0] wb_value
);
  localparam logic [3:0] M_IMM = 4'd0, M_REG = 4'd1, M_BD = 4'd2, M_BX = 4'd3,
                         M_SCL = 4'd4, M_INC = 4'd5, M_DEC = 4'd6, M_UPD = 4'd7,
                         M_IND = 4'd8;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;
  st_t st;

  wire [W-1:0] bd_base = base_is_pc ? pc : base_val;
  wire [W-1:0] scaled  = index_val << scale_sel;
  wire [W-1:0] step_w  = W'(step);
  wire [W-1:0] upd_sum = base_val + disp;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mem_req <= 1'b0;
      mem_addr <= '0;
      done <= 1'b0;
      illegal <= 1'b0;
      operand_valid <= 1'b0;
      operand <= '0;
      addr_valid <= 1'b0;
      addr <= '0;
      wb_en <= 1'b0;
      wb_value <= '0;
    end else begin
      done <= 1'b0;
      illegal <= 1'b0;
      operand_valid <= 1'b0;
      addr_valid <= 1'b0;
      wb_en <= 1'b0;
      mem_req <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (mode == M_IND) begin
            mem_req <= 1'b1;
            mem_addr <= base_val;
            st <= S_REQ;
          end else begin
            done <= 1'b1;
            case (mode)
              M_IMM: begin operand <= imm; operand_valid <= 1'b1; end
              M_REG: begin operand <= base_val; operand_valid <= 1'b1; end
              M_BD:  begin addr <= bd_base + disp; addr_valid <= 1'b1; end
              M_BX:  begin addr <= base_val + index_val; addr_valid <= 1'b1; end
              M_SCL: begin addr <= base_val + scaled; addr_valid <= 1'b1; end
              M_INC: begin
                addr <= base_val; addr_valid <= 1'b1;
                wb_value <= base_val + step_w; wb_en <= 1'b1;
              end
              M_DEC: begin
                addr <= base_val; addr_valid <= 1'b1;
                wb_value <= base_val - step_w; wb_en <= 1'b1;
              end
              M_UPD: begin
                addr <= upd_sum; addr_valid <= 1'b1;
                wb_value <= upd_sum; wb_en <= 1'b1;
              end
              default: illegal <= 1'b1;
            endcase
          end
        end
        S_REQ: st <= S_DATA;
        S_DATA: begin
          addr <= mem_rdata;
          addr_valid <= 1'b1;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode != M_IND) |=> done);
  a_r8_indirect_req: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == M_IND) |=> (mem_req && busy && !done));
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (!operand_valid && !wb_en && !illegal));
  a_r10_illegal_clean: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !addr_valid && !operand_valid && !wb_en));
  a_r2_operand_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    operand_valid |-> (!addr_valid && !mem_req && !wb_en));
  a_r5_wb_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> addr_valid);
  a_r7_result_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({operand_valid, addr_valid, illegal}));
endmodule

// File: tb/tb_opaddr_gen.sv
module tb_opaddr_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MEM_KEY = 32'hA5A5_3C3C;

  logic clk = 0, rst_n = 0, start = 0, base_is_pc = 0;
  logic [3:0] mode = 0;
  logic [31:0] base_val = 0, index_val = 0, disp = 0, imm = 0, pc = 0, mem_rdata = 0;
  logic [1:0] scale_sel = 0;
  logic [2:0] step = 0;
  logic mem_req, busy, done, illegal, operand_valid, addr_valid, wb_en;
  logic [31:0] mem_addr, operand, addr, wb_value;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) mem_rdata <= mem_req ? (mem_addr ^ MEM_KEY) : 32'h0;

  opaddr_gen dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m);
    mode = m; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic expect_addr(input string req, input logic [3:0] m, input logic [31:0] a);
    issue(m);
    chk(req, {done, addr_valid, operand_valid, wb_en}, 4'b1100);
    chk(req, addr, a);
  endtask

  task automatic expect_wb(input string req, input logic [3:0] m, input logic [31:0] a, input logic [31:0] w);
    issue(m);
    chk(req, {done, addr_valid, wb_en, operand_valid}, 4'b1110);
    chk(req, addr, a);
    chk(req, wb_value, w);
  endtask

  task automatic t_reset;
    chk("R1", {done, operand_valid, addr_valid, wb_en, illegal, mem_req, busy}, 7'b0);
  endtask

  task automatic t_operand;
    imm = 32'h0000_1234; base_val = 32'h0BAD_F00D;
    issue(0);
    chk("R2 imm flags", {done, operand_valid, addr_valid, wb_en, mem_req}, 5'b11000);
    chk("R2 imm value", operand, 32'h0000_1234);
    issue(1);
    chk("R2 reg flags", {done, operand_valid, addr_valid, wb_en, mem_req}, 5'b11000);
    chk("R2 reg value", operand, 32'h0BAD_F00D);
  endtask

  task automatic t_base_disp;
    base_val = 32'h0000_1000; pc = 32'h0040_0000; disp = 32'hFFFF_FFF0;
    base_is_pc = 0; expect_addr("R3 base+disp", 2, 32'h0000_0FF0);
    base_is_pc = 1; expect_addr("R3 pc-relative", 2, 32'h003F_FFF0);
    base_is_pc = 0; disp = 0; expect_addr("R3 reg indirect", 2, 32'h0000_1000);
  endtask

  task automatic t_index;
    base_val = 32'h0001_0000; index_val = 32'h0000_0013;
    expect_addr("R4 base+index", 3, 32'h0001_0013);
    for (int s = 0; s < 4; s++) begin
      scale_sel = 2'(s);
      expect_addr("R4 scaled", 4, 32'h0001_0000 + (32'h13 << s));
    end
    scale_sel = 0;
  endtask

  task automatic t_autostep;
    base_val = 32'h0000_2000; step = 4;
    expect_wb("R5 autoinc", 5, 32'h0000_2000, 32'h0000_2004);
    step = 2;
    expect_wb("R5 autodec", 6, 32'h0000_2000, 32'h0000_1FFE);
  endtask

  task automatic t_update;
    base_val = 32'h0000_3000; disp = 32'h10;
    expect_wb("R6 update", 7, 32'h0000_3010, 32'h0000_3010);
  endtask

  task automatic t_wrap;
    base_val = 32'hFFFF_FFF0; disp = 32'h20;
    expect_addr("R11 wrap up", 2, 32'h0000_0010);
    base_val = 0; step = 1;
    expect_wb("R11 wrap down", 6, 32'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_indirect(input logic poke);
    base_val = 32'h0000_8000;
    issue(8);
    chk("R8 req cycle", {mem_req, busy, done}, 3'b110);
    chk("R8 mem_addr", mem_addr, 32'h0000_8000);
    if (poke) begin
      imm = 32'hDEAD_0001; mode = 0; start = 1;
    end
    @(negedge clk); start = 0;
    chk("R9 busy in data cycle", {busy, done, operand_valid}, 3'b100);
    @(negedge clk);
    chk("R8 done", {done, addr_valid, operand_valid, busy}, 4'b1100);
    chk("R8 pointer", addr, 32'h0000_8000 ^ MEM_KEY);
    @(negedge clk);
    chk("R9 no late result", {done, operand_valid}, 2'b00);
  endtask

  task automatic t_illegal;
    for (int m = 9; m < 16; m += 6) begin
      issue(4'(m));
      chk("R10 illegal", {done, illegal, addr_valid, operand_valid, wb_en}, 5'b11000);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        @(negedge clk);
        chk("R7 idle no done", {done, busy}, 2'b00);
        t_operand();
        t_base_disp();
        t_index();
        t_autostep();
        t_update();
        t_wrap();
        t_indirect(0);
        t_indirect(1);
        t_illegal();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule